// File: doc/BRIEF.md
# System Reset Source Combiner

This block gathers every reset source of a small microcontroller system and produces one general system reset. The sources are two supply power-good flags (management supply and digital core supply), an active-low external reset pad, a bus-error detector on the processor's address bus, a watchdog reset request and a port-triggered reset request. The block also drives the pull on the reset pad from the management-supply power-good flag. When the pad is left open, the supply state therefore reaches the system reset through the pad as well as directly.

Each source asserts the system reset asynchronously. Release happens only after every source has gone quiet. The release edge passes through a two-stage synchroniser and then waits a parameterised number of further cycles. A parameterised table of inclusive base/limit address windows defines the memory map. When software has set the bus-error enable, a qualified access outside every window raises a reset. A cause register records which sources started the most recent reset, so software can read it after start-up.

All pins are plain level signals. No interface here carries a data stream, so there is no valid/ready back-pressure. The access strobe on the bus side is a qualifier only and is never stalled.

Top module: `sys_reset_combiner`

## Requirements
- R1: `sys_rst_n_o` is low whenever `mgmt_pwr_good_i` or `core_pwr_good_i` is low, at once and without waiting for a clock edge. Raising only one of the two flags does not release the reset.
- R2: After the system has been released, dropping either power-good flag (a brownout) returns `sys_rst_n_o` low at once.
- R3: `pad_pull_en_o` equals `mgmt_pwr_good_i`. A low level on `ext_rst_pad_n_i` drives `sys_rst_n_o` low at once.
- R4: The bus-error enable reads back on `buserr_en_o`. A clocked write through `buserr_en_wr_i` sets it to the value on `buserr_en_wdata_i`. Every reset source clears it, so after any reset it reads 0.
- R5: An access has `bus_valid_i` high at a rising edge and an address outside every window. If the enable is 1 at that edge, `sys_rst_n_o` is low before the next rising edge. With the enable at 0, or with `bus_valid_i` low, the same address has no effect.
- R6: A high level on `wdog_rst_req_i` or on `port_rst_req_i` drives `sys_rst_n_o` low at once.
- R7: Once every source is inactive, `sys_rst_n_o` stays low through the first HOLD_CYCLES+2 rising edges. It rises after edge number HOLD_CYCLES+3 (7 with the default HOLD_CYCLES of 4).
- R8: `rst_cause_o` has one bit per source: bit 0 power, bit 1 pad, bit 2 bus error, bit 3 watchdog, bit 4 port. A power-on or brownout event sets it to 5'b00001, dropping all other bits. Any other reset that starts while the system is running replaces the contents with the sources active at its first edge. The register keeps its value after release.
- R9: Window bounds are inclusive. Accesses at the base and at the limit of each window never cause a bus-error reset. The default windows are 0x0000-0x1FFF, 0x4000-0x40FF and 0x8000-0xBFFF, so 0x2000 is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mgmt_pwr_good_i | input | 1 | Management-supply power good, high when valid |
| core_pwr_good_i | input | 1 | Digital core supply power good, high when valid |
| ext_rst_pad_n_i | input | 1 | External reset pad level, active low |
| pad_pull_en_o | output | 1 | Enables the pull-up on the reset pad |
| bus_valid_i | input | 1 | Processor access strobe (read or write) |
| bus_addr_i | input | ADDR_W | Processor access address |
| buserr_en_wr_i | input | 1 | Write strobe for the bus-error enable |
| buserr_en_wdata_i | input | 1 | Value written to the bus-error enable |
| buserr_en_o | output | 1 | Current bus-error enable |
| wdog_rst_req_i | input | 1 | Watchdog reset request, active high |
| port_rst_req_i | input | 1 | Port-triggered reset request, active high |
| sys_rst_n_o | output | 1 | General system reset, active low |
| rst_cause_o | output | 5 | Cause of the last reset, one bit per source |

## Verification
The bench brings up one supply flag before the other. A design that released on either flag alone would let the system run with a dead core supply. It counts release edges exactly after power-up and after a pad press. A synchroniser or stretch counter that is one stage short would release a cycle early. It probes the first and last address of every window, with the enable set, plus an unmapped address with the strobe low. Inclusive/exclusive mistakes or a missing strobe qualifier would show up as spurious resets. It also checks that a brownout after a pad reset wipes the old cause, and that watchdog and port requests in the same cycle both land in the cause register. A design that ORed across episodes or latched only one source would report the wrong origin.

// File: rtl/rst_comb_pkg.sv
package rst_comb_pkg;

  localparam int CAUSE_W = 5;

  typedef enum int unsigned {
    CAUSE_POWER  = 0,
    CAUSE_PAD    = 1,
    CAUSE_BUSERR = 2,
    CAUSE_WDOG   = 3,
    CAUSE_PORT   = 4
  } cause_idx_e;

  typedef logic [CAUSE_W-1:0] cause_t;

  function automatic cause_t cause_bit(cause_idx_e idx);
    cause_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/rst_addr_decoder.sv
module rst_addr_decoder #(
  parameter int ADDR_W  = 16,
  parameter int NRANGES = 3,
  parameter logic [NRANGES*ADDR_W-1:0] RANGE_BASE  = '0,
  parameter logic [NRANGES*ADDR_W-1:0] RANGE_LIMIT = '1
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  logic [NRANGES-1:0] in_win;

  for (genvar g = 0; g < NRANGES; g++) begin : g_win
    localparam logic [ADDR_W-1:0] LO = RANGE_BASE[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = RANGE_LIMIT[g*ADDR_W +: ADDR_W];

    always_comb in_win[g] = (addr_i >= LO) && (addr_i <= HI);

    // A base or limit address must always decode as mapped
    assert_edges_mapped_R9: assert property (@(posedge clk)
      ((addr_i == LO) || (addr_i == HI)) |-> hit_o);
  end

  assign hit_o = |in_win;

endmodule

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_async_i,
  output logic rel_o
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   rel_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or posedge rst_async_i) begin
      if (rst_async_i) sync_q[s] <= 1'b0;
      else if (s == 0)  sync_q[s] <= 1'b1;
      else              sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  logic synced;
  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or posedge rst_async_i) begin
    if (rst_async_i)                    cnt_q <= '0;
    else if (synced && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or posedge rst_async_i) begin
    if (rst_async_i) rel_q <= 1'b0;
    else             rel_q <= (cnt_q == CNT_MAX);
  end

  assign rel_o = rel_q;

  // Release can never precede the synchronised edge
  assert_no_early_release_R7: assert property (@(posedge clk)
    disable iff (rst_async_i) !synced |=> !rel_q);

  // Once released, only a reset source takes the release back
  assert_release_sticky_R7: assert property (@(posedge clk)
    disable iff (rst_async_i) rel_q |=> rel_q);

  // While a source is active, release stays low
  assert_held_in_reset_R7: assert property (@(posedge clk)
    rst_async_i |-> !rel_q);

endmodule

// File: rtl/rst_cause_log.sv
module rst_cause_log
  import rst_comb_pkg::*;
(
  input  logic   clk,
  input  logic   power_evt_i,
  input  cause_t src_i,
  input  logic   released_i,
  output cause_t cause_o
);

  cause_t cause_q;
  logic   armed_q;

  always_ff @(posedge clk or posedge power_evt_i) begin
    if (power_evt_i) begin
      cause_q <= cause_bit(CAUSE_POWER);
      armed_q <= 1'b0;
    end else if (src_i != '0) begin
      if (armed_q) begin
        cause_q <= src_i;
        armed_q <= 1'b0;
      end else begin
        cause_q <= cause_q | src_i;
      end
    end else if (released_i) begin
      armed_q <= 1'b1;
    end
  end

  assign cause_o = cause_q;

  // A power event leaves only the power bit
  assert_power_clears_R8: assert property (@(posedge clk)
    power_evt_i |-> (cause_o == cause_bit(CAUSE_POWER)));

  // A running-system reset overwrites the previous record
  assert_new_episode_R8: assert property (@(posedge clk)
    disable iff (power_evt_i) (armed_q && src_i != '0) |=> (cause_o == $past(src_i)));

endmodule

// File: rtl/sys_reset_combiner.sv
module sys_reset_combiner
  import rst_comb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NRANGES     = 3,
  parameter logic [NRANGES*ADDR_W-1:0] RANGE_BASE  = {16'h8000, 16'h4000, 16'h0000},
  parameter logic [NRANGES*ADDR_W-1:0] RANGE_LIMIT = {16'hBFFF, 16'h40FF, 16'h1FFF},
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              mgmt_pwr_good_i,
  input  logic              core_pwr_good_i,
  input  logic              ext_rst_pad_n_i,
  output logic              pad_pull_en_o,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              buserr_en_wr_i,
  input  logic              buserr_en_wdata_i,
  output logic              buserr_en_o,
  input  logic              wdog_rst_req_i,
  input  logic              port_rst_req_i,
  output logic              sys_rst_n_o,
  output logic [CAUSE_W-1:0] rst_cause_o
);

  logic   power_evt;
  logic   pad_rst;
  logic   addr_hit;
  logic   buserr_en_q;
  logic   buserr_q;
  logic   rst_any;
  logic   released;
  cause_t src_vec;

  assign power_evt     = !(mgmt_pwr_good_i && core_pwr_good_i);
  assign pad_pull_en_o = mgmt_pwr_good_i;
  assign pad_rst       = !ext_rst_pad_n_i;

  rst_addr_decoder #(
    .ADDR_W     (ADDR_W),
    .NRANGES    (NRANGES),
    .RANGE_BASE (RANGE_BASE),
    .RANGE_LIMIT(RANGE_LIMIT)
  ) u_dec (
    .clk   (clk),
    .addr_i(bus_addr_i),
    .hit_o (addr_hit)
  );

  // Enable bit: cleared by every source, written by software
  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any)             buserr_en_q <= 1'b0;
    else if (buserr_en_wr_i) buserr_en_q <= buserr_en_wdata_i;
  end

  // Registered bus-error request; it self-clears once the enable drops
  always_ff @(posedge clk or posedge power_evt) begin
    if (power_evt) buserr_q <= 1'b0;
    else           buserr_q <= buserr_en_q && bus_valid_i && !addr_hit;
  end

  assign rst_any = power_evt | pad_rst | buserr_q | wdog_rst_req_i | port_rst_req_i;

  rst_release_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_rel (
    .clk        (clk),
    .rst_async_i(rst_any),
    .rel_o      (released)
  );

  always_comb begin
    src_vec = '0;
    src_vec[CAUSE_PAD]    = pad_rst;
    src_vec[CAUSE_BUSERR] = buserr_q;
    src_vec[CAUSE_WDOG]   = wdog_rst_req_i;
    src_vec[CAUSE_PORT]   = port_rst_req_i;
  end

  rst_cause_log u_cause (
    .clk        (clk),
    .power_evt_i(power_evt),
    .src_i      (src_vec),
    .released_i (released),
    .cause_o    (rst_cause_o)
  );

  assign buserr_en_o = buserr_en_q;
  assign sys_rst_n_o = released;

  assert_supply_holds_R1: assert property (@(posedge clk)
    power_evt |-> !sys_rst_n_o);

  assert_pad_resets_R3: assert property (@(posedge clk)
    disable iff (power_evt) !ext_rst_pad_n_i |-> !sys_rst_n_o);

  assert_unmapped_resets_R5: assert property (@(posedge clk)
    disable iff (power_evt) (buserr_en_o && bus_valid_i && !addr_hit) |=> !sys_rst_n_o);

  assert_enable_cleared_R4: assert property (@(posedge clk)
    disable iff (power_evt) (wdog_rst_req_i || port_rst_req_i || pad_rst) |-> !buserr_en_o);

  assert_requests_reset_R6: assert property (@(posedge clk)
    disable iff (power_evt) (wdog_rst_req_i || port_rst_req_i) |-> !sys_rst_n_o);

endmodule

// File: tb/sys_reset_combiner_bench.sv
module sys_reset_combiner_bench;

  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        mgmt_pg = 1'b0, core_pg = 1'b0;
  logic        pad_gnd = 1'b0;
  logic        pad_n;
  logic        pad_pull;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        en_wr = 1'b0, en_wdata = 1'b0;
  logic        en_rd;
  logic        wdog = 1'b0, port = 1'b0;
  logic        rst_n;
  logic [4:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Open pad reads the pull level; pressing it shorts to ground
  assign pad_n = pad_gnd ? 1'b0 : pad_pull;

  sys_reset_combiner #(.HOLD_CYCLES(HOLD)) u_sys_reset_combiner (
    .clk              (clk),
    .mgmt_pwr_good_i  (mgmt_pg),
    .core_pwr_good_i  (core_pg),
    .ext_rst_pad_n_i  (pad_n),
    .pad_pull_en_o    (pad_pull),
    .bus_valid_i      (bus_valid),
    .bus_addr_i       (bus_addr),
    .buserr_en_wr_i   (en_wr),
    .buserr_en_wdata_i(en_wdata),
    .buserr_en_o      (en_rd),
    .wdog_rst_req_i   (wdog),
    .port_rst_req_i   (port),
    .sys_rst_n_o      (rst_n),
    .rst_cause_o      (cause)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_release(input string req);
    repeat (HOLD + 2) @(posedge clk);
    @(negedge clk);
    check(rst_n == 1'b0, req, rst_n, 0);
    @(posedge clk);
    @(negedge clk);
    check(rst_n == 1'b1, req, rst_n, 1);
  endtask

  task automatic wait_loose();
    for (int i = 0; i < 40 && rst_n !== 1'b1; i++) @(negedge clk);
    check(rst_n == 1'b1, "release", rst_n, 1);
  endtask

  task automatic set_enable(input logic v);
    @(negedge clk);
    en_wr = 1'b1; en_wdata = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input logic v, input logic exp_rst_n, input string req);
    @(negedge clk);
    bus_valid = v; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check(rst_n == exp_rst_n, req, {a, 15'b0, rst_n}, {a, 15'b0, exp_rst_n});
  endtask

  task automatic t_power_up();
    repeat (3) @(negedge clk);
    check(rst_n == 1'b0, "R1 reset state", rst_n, 0);
    check(cause == 5'b00001, "R8 reset state", cause, 5'b00001);
    check(pad_pull == 1'b0, "R3 pull off", pad_pull, 0);
    mgmt_pg = 1'b1;
    repeat (12) @(negedge clk);
    check(rst_n == 1'b0, "R1 one supply only", rst_n, 0);
    check(pad_pull == 1'b1, "R3 pull on", pad_pull, 1);
    core_pg = 1'b1;
    expect_release("R7 power-up release");
    check(cause == 5'b00001, "R8 power cause", cause, 5'b00001);
    check(en_rd == 1'b0, "R4 enable off after reset", en_rd, 0);
  endtask

  task automatic t_pad();
    @(negedge clk);
    pad_gnd = 1'b1;
    #1 check(rst_n == 1'b0, "R3 pad assert", rst_n, 0);
    @(negedge clk);
    check(cause == 5'b00010, "R8 pad cause", cause, 5'b00010);
    pad_gnd = 1'b0;
    expect_release("R7 pad release");
    check(cause == 5'b00010, "R8 cause kept", cause, 5'b00010);
  endtask

  task automatic t_brownout();
    @(negedge clk);
    core_pg = 1'b0;
    #1 check(rst_n == 1'b0, "R2 brownout", rst_n, 0);
    check(cause == 5'b00001, "R8 brownout clears", cause, 5'b00001);
    @(negedge clk);
    core_pg = 1'b1;
    wait_loose();
  endtask

  task automatic t_bus_error();
    access(16'h2000, 1'b1, 1'b1, "R5 enable clear ignores");
    set_enable(1'b1);
    check(en_rd == 1'b1, "R4 enable write", en_rd, 1);
    access(16'h0000, 1'b1, 1'b1, "R9 base0");
    access(16'h1FFF, 1'b1, 1'b1, "R9 limit0");
    access(16'h4000, 1'b1, 1'b1, "R9 base1");
    access(16'h40FF, 1'b1, 1'b1, "R9 limit1");
    access(16'h8000, 1'b1, 1'b1, "R9 base2");
    access(16'hBFFF, 1'b1, 1'b1, "R9 limit2");
    access(16'h2000, 1'b0, 1'b1, "R5 no strobe ignores");
    access(16'h2000, 1'b1, 1'b0, "R5 unmapped resets");
    check(en_rd == 1'b0, "R4 enable cleared", en_rd, 0);
    wait_loose();
    check(cause == 5'b00100, "R8 bus error cause", cause, 5'b00100);
    check(en_rd == 1'b0, "R4 enable off after release", en_rd, 0);
  endtask

  task automatic t_requests(input logic w, input logic p, input logic [4:0] exp_cause, input string req);
    set_enable(1'b1);
    @(negedge clk);
    wdog = w; port = p;
    #1 check(rst_n == 1'b0, req, rst_n, 0);
    check(en_rd == 1'b0, "R4 enable cleared by request", en_rd, 0);
    @(negedge clk);
    wdog = 1'b0; port = 1'b0;
    wait_loose();
    check(cause == exp_cause, "R8 request cause", cause, exp_cause);
  endtask

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_power_up();
    t_pad();
    t_brownout();
    t_bus_error();
    t_requests(1'b1, 1'b0, 5'b01000, "R6 watchdog");
    t_requests(1'b0, 1'b1, 5'b10000, "R6 port");
    t_requests(1'b1, 1'b1, 5'b11000, "R6 both");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule